// File: doc/BRIEF.md
# Slot-Table Fragment Service Scheduler

This block decides, on the receive side, which channel's buffer is drained next and how large a piece is taken from it. Software loads a table of up to 64 slots. Each slot names one channel, or holds the code 0, which means "do nothing this slot". The scheduler steps through the slots at a fixed, programmable pace and looks at one entry per slot. A fast channel gets a fair share of service by being listed in more slots than a slow one. When every channel runs at the same rate, the table is just each channel once.

For a channel slot, the scheduler reads the channel's buffer status: a byte count and a flag that marks a buffered end of message. The channel is served only when one of two things holds. Either a whole fragment is waiting, or a message end is buffered before that much data has built up. When it is served, at most one fragment request is raised on a valid/ready output. The request carries the channel, the byte length and an end-of-message tag. A request that is still waiting when the slot ends is withdrawn.

Top module: `frag_slot_sched`

## Requirements
- R1: A write on the table port stores the given channel number at the given slot index, and later visits to that slot use it. Reset clears every slot to the no-operation code 0.
- R2: A slot that holds channel 0 never raises a request (`req_valid_o` stays 0 for that slot).
- R3: Within one slot, at most one request is accepted. After the handshake (`req_valid_o` and `req_ready_i` both high on a clock edge), `req_valid_o` stays low until the next slot starts.
- R4: A channel whose byte count is at least the fragment size is served with length equal to the fragment size. The request is tagged end-of-message only when the end flag is set and the byte count equals the fragment size, because the message end is taken to be the last buffered byte.
- R5: A channel whose byte count is non-zero but below the fragment size is served only when its end flag is set. It is then served with length equal to the byte count and with the end-of-message tag set. A set end flag with a byte count of 0 raises no request.
- R6: The fragment size equals `cfg_frag_units_i` times 4 bytes. The value 0 means 64 units, which is 256 bytes.
- R7: Each slot lasts `cfg_slot_time_i + 1` clock cycles. The first slot starts on the first clock edge after reset is released. A slot's request is visible from the cycle after the edge that starts that slot.
- R8: After the slot whose index equals `cfg_last_slot_i`, the next slot is slot 0. Slots beyond that index are never visited.
- R9: A request that is not accepted is held stable, with the same channel, length and tag, until the slot ends. It is then dropped, and the next slot is served without a retry.
- R10: A channel slot whose channel does not qualify under R4 or R5 raises no request, and its slot passes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tbl_wr_en_i | input | 1 | Table write strobe |
| tbl_wr_addr_i | input | IDX_W (6) | Slot index to write |
| tbl_wr_ch_i | input | CH_W (3) | Channel number to store (0 = no-op) |
| cfg_last_slot_i | input | IDX_W (6) | Index of the last slot in use |
| cfg_slot_time_i | input | SLOT_W (8) | Slot length in cycles, minus one |
| cfg_frag_units_i | input | 6 | Fragment size in 4-byte units (0 = 64) |
| buf_bytes_i | input | NUM_CH*CNT_W (70) | Byte count per channel; channel c is at bits [(c-1)*CNT_W +: CNT_W] |
| buf_eom_i | input | NUM_CH (7) | End-of-message buffered flag per channel; channel c is at bit c-1 |
| req_valid_o | output | 1 | Fragment request valid |
| req_ready_i | input | 1 | Fragment request accepted |
| req_ch_o | output | CH_W (3) | Channel of the request |
| req_len_o | output | 9 | Fragment length in bytes (1..256) |
| req_eom_o | output | 1 | Fragment ends a message |

## Verification
Four properties are checked on every cycle:
- No request ever names channel 0.
- A request that was accepted is not raised again within the same slot.
- A request that is waiting keeps its channel, length and tag until it is accepted or its slot ends.
- Each request's length lies between 1 and the fragment size that applied when its slot began.

The other behaviours can only be shown by the bench's scenarios: the exact fragment length and end-of-message tag for each mix of byte count, end flag and fragment size; the order of slots in a weighted table, including the wrap at the last slot; and the number of slots that fit into a given number of cycles.

// File: rtl/frag_sched_pkg.sv
package frag_sched_pkg;
    // Largest fragment a single service may move.
    localparam int FRAG_MAX_BYTES = 256;
    localparam int LEN_W          = $clog2(FRAG_MAX_BYTES) + 1;
    localparam int UNIT_W         = $clog2(FRAG_MAX_BYTES / 4);

    // Fragment size register (4-byte units) to bytes; 0 stands for the maximum.
    function automatic logic [LEN_W-1:0] units_to_bytes(input logic [UNIT_W-1:0] units);
        logic [LEN_W-1:0] res;
        if (units == '0) begin
            res = LEN_W'(FRAG_MAX_BYTES);
        end else begin
            res = {{(LEN_W-UNIT_W-2){1'b0}}, units, 2'b00};
        end
        return res;
    endfunction
endpackage

// File: rtl/slot_table.sv
module slot_table #(
    parameter int CH_W  = 3,
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_addr_i,
    input  logic [CH_W-1:0]  wr_ch_i,
    input  logic [IDX_W-1:0] rd_addr_i,
    output logic [CH_W-1:0]  rd_ch_o
);
    typedef logic [CH_W-1:0] entry_t;

    entry_t mem_d [DEPTH];
    entry_t mem_q [DEPTH];

    // One write decoder per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en_i && (int'(wr_addr_i) == g)) begin
                mem_d[g] = wr_ch_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    always_comb begin
        rd_ch_o = '0;
        if (int'(rd_addr_i) < DEPTH) begin
            rd_ch_o = mem_q[rd_addr_i];
        end
    end
endmodule

// File: rtl/slot_pacer.sv
module slot_pacer #(
    parameter int IDX_W  = 6,
    parameter int SLOT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IDX_W-1:0]  cfg_last_slot_i,
    input  logic [SLOT_W-1:0] cfg_slot_time_i,
    output logic              load_o,
    output logic [IDX_W-1:0]  load_idx_o
);
    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] tmr;
        logic [IDX_W-1:0]  ptr;
    } pace_t;

    pace_t st_d, st_q;
    logic  load_d;
    logic [IDX_W-1:0] nxt_d;

    always_comb begin
        st_d = st_q;
        // The slot ends once the timer reaches the programmed time; the
        // comparison is >= so a shortened slot time takes effect at once.
        load_d = !st_q.run || (st_q.tmr >= cfg_slot_time_i);
        if (!st_q.run || (st_q.ptr >= cfg_last_slot_i)) begin
            nxt_d = '0;
        end else begin
            nxt_d = st_q.ptr + 1'b1;
        end
        if (load_d) begin
            st_d.run = 1'b1;
            st_d.tmr = '0;
            st_d.ptr = nxt_d;
        end else begin
            st_d.tmr = st_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o     = load_d;
    assign load_idx_o = nxt_d;
endmodule

// File: rtl/frag_qualify.sv
module frag_qualify
    import frag_sched_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CNT_W = 10,
    localparam int NUM_CH = (1 << CH_W) - 1
) (
    input  logic [CH_W-1:0]         ch_i,
    input  logic [NUM_CH*CNT_W-1:0] buf_bytes_i,
    input  logic [NUM_CH-1:0]       buf_eom_i,
    input  logic [UNIT_W-1:0]       frag_units_i,
    output logic                    hit_o,
    output logic [LEN_W-1:0]        len_o,
    output logic                    eom_o
);
    localparam int CMP_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;

    logic [CNT_W-1:0] cnt_arr [NUM_CH+1];
    logic             eom_arr [NUM_CH+1];

    // Channel 0 is the no-op code and always reads as empty.
    assign cnt_arr[0] = '0;
    assign eom_arr[0] = 1'b0;
    for (genvar g = 1; g <= NUM_CH; g++) begin : g_ch
        assign cnt_arr[g] = buf_bytes_i[(g-1)*CNT_W +: CNT_W];
        assign eom_arr[g] = buf_eom_i[g-1];
    end

    logic [CMP_W-1:0] have_c;
    logic [CMP_W-1:0] frag_c;
    logic             full_c;
    logic             tail_c;
    logic             eom_c;

    always_comb begin
        have_c = CMP_W'(cnt_arr[ch_i]);
        eom_c  = eom_arr[ch_i];
        frag_c = CMP_W'(units_to_bytes(frag_units_i));
        full_c = (ch_i != '0) && (have_c >= frag_c);
        tail_c = (ch_i != '0) && eom_c && (have_c != '0);
        hit_o  = full_c || tail_c;
        len_o  = full_c ? LEN_W'(frag_c) : LEN_W'(have_c);
        // The message end is the last buffered byte: it lies in this
        // fragment only when everything buffered fits.
        eom_o  = hit_o && eom_c && (have_c <= frag_c);
    end
endmodule

// File: rtl/frag_slot_sched.sv
module frag_slot_sched
    import frag_sched_pkg::*;
#(
    parameter int CH_W      = 3,
    parameter int CNT_W     = 10,
    parameter int TBL_DEPTH = 64,
    parameter int SLOT_W    = 8,
    localparam int IDX_W  = $clog2(TBL_DEPTH),
    localparam int NUM_CH = (1 << CH_W) - 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    tbl_wr_en_i,
    input  logic [IDX_W-1:0]        tbl_wr_addr_i,
    input  logic [CH_W-1:0]         tbl_wr_ch_i,
    input  logic [IDX_W-1:0]        cfg_last_slot_i,
    input  logic [SLOT_W-1:0]       cfg_slot_time_i,
    input  logic [UNIT_W-1:0]       cfg_frag_units_i,
    input  logic [NUM_CH*CNT_W-1:0] buf_bytes_i,
    input  logic [NUM_CH-1:0]       buf_eom_i,
    output logic                    req_valid_o,
    input  logic                    req_ready_i,
    output logic [CH_W-1:0]         req_ch_o,
    output logic [LEN_W-1:0]        req_len_o,
    output logic                    req_eom_o
);
    typedef struct packed {
        logic             valid;
        logic [CH_W-1:0]  ch;
        logic [LEN_W-1:0] len;
        logic             eom;
    } req_t;

    logic             slot_load;
    logic [IDX_W-1:0] slot_idx;
    logic [CH_W-1:0]  slot_ch;
    logic             q_hit;
    logic [LEN_W-1:0] q_len;
    logic             q_eom;

    slot_pacer #(
        .IDX_W  (IDX_W),
        .SLOT_W (SLOT_W)
    ) pacer_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .cfg_last_slot_i (cfg_last_slot_i),
        .cfg_slot_time_i (cfg_slot_time_i),
        .load_o          (slot_load),
        .load_idx_o      (slot_idx)
    );

    slot_table #(
        .CH_W  (CH_W),
        .DEPTH (TBL_DEPTH)
    ) table_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (tbl_wr_en_i),
        .wr_addr_i (tbl_wr_addr_i),
        .wr_ch_i   (tbl_wr_ch_i),
        .rd_addr_i (slot_idx),
        .rd_ch_o   (slot_ch)
    );

    frag_qualify #(
        .CH_W  (CH_W),
        .CNT_W (CNT_W)
    ) qual_i (
        .ch_i         (slot_ch),
        .buf_bytes_i  (buf_bytes_i),
        .buf_eom_i    (buf_eom_i),
        .frag_units_i (cfg_frag_units_i),
        .hit_o        (q_hit),
        .len_o        (q_len),
        .eom_o        (q_eom)
    );

    req_t req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (req_q.valid && req_ready_i) begin
            req_d.valid = 1'b0;
        end
        // A slot boundary replaces whatever is pending: an unaccepted
        // request is forfeited here.
        if (slot_load) begin
            req_d.valid = q_hit;
            req_d.ch    = slot_ch;
            req_d.len   = q_len;
            req_d.eom   = q_eom;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_valid_o = req_q.valid;
    assign req_ch_o    = req_q.ch;
    assign req_len_o   = req_q.len;
    assign req_eom_o   = req_q.eom;
endmodule

// File: rtl/frag_slot_sched_chk.sv
module frag_slot_sched_chk
    import frag_sched_pkg::*;
#(
    parameter int CH_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              slot_load,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [CH_W-1:0]   req_ch_o,
    input logic [LEN_W-1:0]  req_len_o,
    input logic              req_eom_o,
    input logic [UNIT_W-1:0] cfg_frag_units_i
);
    // R2: a visible request never names the no-op channel.
    p_no_nop_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> (req_ch_o != '0));

    // R3: once accepted mid-slot, no second request in the same slot.
    p_one_per_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && req_ready_i && !slot_load) |=> !req_valid_o);

    // R9: a waiting request holds its fields until accepted or slot end.
    p_hold_until_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && !req_ready_i && !slot_load) |=>
            (req_valid_o && $stable(req_ch_o) && $stable(req_len_o) && $stable(req_eom_o)));

    // R6: a fresh request is non-empty and within the fragment size of its slot.
    p_len_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(slot_load) && req_valid_o) |->
            ((req_len_o != '0) && (req_len_o <= units_to_bytes($past(cfg_frag_units_i)))));
endmodule

bind frag_slot_sched frag_slot_sched_chk #(
    .CH_W (CH_W)
) chk_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .slot_load        (slot_load),
    .req_valid_o      (req_valid_o),
    .req_ready_i      (req_ready_i),
    .req_ch_o         (req_ch_o),
    .req_len_o        (req_len_o),
    .req_eom_o        (req_eom_o),
    .cfg_frag_units_i (cfg_frag_units_i)
);

// File: tb/frag_slot_sched_tb_top.sv
`timescale 1ns/1ps
module frag_slot_sched_tb_top;
    localparam int CH_W   = 3;
    localparam int CNT_W  = 10;
    localparam int DEPTH  = 64;
    localparam int SLOT_W = 8;
    localparam int IDX_W  = 6;
    localparam int NCH    = 7;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_en = 1'b0;
    logic [IDX_W-1:0]       wr_addr = '0;
    logic [CH_W-1:0]        wr_ch = '0;
    logic [IDX_W-1:0]       last_slot = '0;
    logic [SLOT_W-1:0]      slot_time = 8'd3;
    logic [5:0]             units = 6'd16;
    logic [NCH*CNT_W-1:0]   bytes_flat;
    logic [NCH-1:0]         eom_flags;
    logic                   ready = 1'b0;
    logic                   valid;
    logic [CH_W-1:0]        ch;
    logic [8:0]             len;
    logic                   eom;

    logic [CNT_W-1:0] cnt_tb [NCH];
    logic             eom_tb [NCH];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            bytes_flat[i*CNT_W +: CNT_W] = cnt_tb[i];
            eom_flags[i]                 = eom_tb[i];
        end
    end

    always #10 clk = ~clk;

    frag_slot_sched #(
        .CH_W      (CH_W),
        .CNT_W     (CNT_W),
        .TBL_DEPTH (DEPTH),
        .SLOT_W    (SLOT_W)
    ) dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .tbl_wr_en_i      (wr_en),
        .tbl_wr_addr_i    (wr_addr),
        .tbl_wr_ch_i      (wr_ch),
        .cfg_last_slot_i  (last_slot),
        .cfg_slot_time_i  (slot_time),
        .cfg_frag_units_i (units),
        .buf_bytes_i      (bytes_flat),
        .buf_eom_i        (eom_flags),
        .req_valid_o      (valid),
        .req_ready_i      (ready),
        .req_ch_o         (ch),
        .req_len_o        (len),
        .req_eom_o        (eom)
    );

    int compared   = 0;
    int mismatched = 0;
    int edge_cnt   = 0;
    int accepts    = 0;
    int period     = 4;

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
        if (rst_n && valid && ready) accepts <= accepts + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Returns 1 ns after the next edge that starts a slot.
    task automatic wait_load();
        forever begin
            step();
            if (((edge_cnt - 1) % period) == 0) break;
        end
    endtask

    task automatic write_slot(input int idx, input int c);
        wr_en   = 1'b1;
        wr_addr = IDX_W'(idx);
        wr_ch   = CH_W'(c);
        step();
        wr_en   = 1'b0;
    endtask

    task automatic do_reset(input int st);
        rst_n     = 1'b0;
        slot_time = SLOT_W'(st);
        period    = st + 1;
        repeat (3) step();
        check("R7 reset valid", int'(valid), 0);
        rst_n = 1'b1;
    endtask

    typedef struct packed {
        logic [9:0] bytes;
        logic       flag;
        logic [5:0] un;
        logic       v;
        logic [8:0] ln;
        logic       e;
    } vec_t;

    // Channel 1 alone in the table; one vector per slot.
    localparam vec_t VECS [10] = '{
        '{10'd100, 1'b0, 6'd16, 1'b1, 9'd64,  1'b0},  // R4 full fragment
        '{10'd40,  1'b0, 6'd16, 1'b0, 9'd0,   1'b0},  // R10 too little, no end
        '{10'd40,  1'b1, 6'd16, 1'b1, 9'd40,  1'b1},  // R5 short message end
        '{10'd64,  1'b1, 6'd16, 1'b1, 9'd64,  1'b1},  // R4 end exactly at size
        '{10'd65,  1'b1, 6'd16, 1'b1, 9'd64,  1'b0},  // R4 end beyond fragment
        '{10'd0,   1'b1, 6'd16, 1'b0, 9'd0,   1'b0},  // R5 empty with end flag
        '{10'd300, 1'b0, 6'd0,  1'b1, 9'd256, 1'b0},  // R6 zero means 256
        '{10'd255, 1'b0, 6'd0,  1'b0, 9'd0,   1'b0},  // R6 255 < 256
        '{10'd4,   1'b0, 6'd1,  1'b1, 9'd4,   1'b0},  // R6 one unit
        '{10'd252, 1'b1, 6'd63, 1'b1, 9'd252, 1'b1}   // R6 63 units
    };

    initial begin
        #(20 * 200000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            cnt_tb[i] = 10'd100;
            eom_tb[i] = 1'b0;
        end
        #1;
        do_reset(3);

        // R1 reset: cleared table gives only idle slots despite full buffers.
        for (int s = 0; s < 3; s++) begin
            wait_load();
            check("R1 cleared table idle", int'(valid), 0);
        end

        write_slot(0, 1);
        wait_load();

        // Vector walk.
        for (int k = 0; k < 10; k++) begin
            cnt_tb[0] = VECS[k].bytes;
            eom_tb[0] = VECS[k].flag;
            units     = VECS[k].un;
            wait_load();
            check($sformatf("R4/R5/R6/R10 vec%0d valid", k), int'(valid), int'(VECS[k].v));
            if (VECS[k].v) begin
                check($sformatf("R4/R5/R6 vec%0d len", k), int'(len), int'(VECS[k].ln));
                check($sformatf("R4/R5 vec%0d eom", k), int'(eom), int'(VECS[k].e));
                check($sformatf("R1 vec%0d ch", k), int'(ch), 1);
            end
        end

        // R3: one accept per slot, then quiet for the rest of the slot.
        cnt_tb[0] = 10'd100;
        eom_tb[0] = 1'b0;
        units     = 6'd16;
        wait_load();
        check("R3 offered", int'(valid), 1);
        ready = 1'b1;
        step();
        check("R3 dropped after accept", int'(valid), 0);
        step();
        step();
        check("R3 still quiet in slot", int'(valid), 0);
        ready = 1'b0;

        // R9: unaccepted request held, then forfeited at the slot end.
        wait_load();
        check("R9 offered", int'(valid), 1);
        for (int c = 0; c < 3; c++) begin
            step();
            check("R9 held valid", int'(valid), 1);
            check("R9 held len", int'(len), 64);
        end
        cnt_tb[0] = 10'd10;
        step();
        check("R9 forfeited at slot end", int'(valid), 0);
        cnt_tb[0] = 10'd100;

        // R7: an 8-cycle window at 4-cycle slots holds 2 accepts.
        wait_load();
        ready   = 1'b1;
        accepts = 0;
        repeat (8) step();
        check("R7 accepts in 8 cycles, slot 4", accepts, 2);
        ready = 1'b0;

        // R8/R1/R2: weighted table with wrap; slot 5 lies beyond the end.
        cnt_tb[1] = 10'd120;
        cnt_tb[2] = 10'd200;
        cnt_tb[3] = 10'd50;
        write_slot(1, 2);
        write_slot(2, 1);
        write_slot(3, 3);
        write_slot(4, 0);
        write_slot(5, 4);
        wait_load();
        last_slot = 6'd4;
        begin
            int exp_seq [10] = '{2, 1, 3, 0, 1, 2, 1, 3, 0, 1};
            for (int s = 0; s < 10; s++) begin
                wait_load();
                check($sformatf("R8/R2 slot%0d valid", s), int'(valid), int'(exp_seq[s] != 0));
                if (exp_seq[s] != 0)
                    check($sformatf("R8/R1 slot%0d ch", s), int'(ch), exp_seq[s]);
            end
        end

        // R7: 2-cycle slots, then 1-cycle slots.
        last_slot = '0;
        do_reset(1);
        write_slot(0, 1);
        wait_load();
        ready   = 1'b1;
        accepts = 0;
        repeat (8) step();
        check("R7 accepts in 8 cycles, slot 2", accepts, 4);
        slot_time = '0;
        period    = 1;
        wait_load();
        accepts = 0;
        repeat (8) step();
        check("R7 accepts in 8 cycles, slot 1", accepts, 8);
        ready = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule